// File: doc/BRIEF.md
# Host Window onto Coprocessor Data Memory

This block gives a host processor a way into the private data memory of a coprocessor. The host sees four 16-bit registers on a simple read/write register bus. One register is a data window, one holds a word address, one holds configuration and one reports status. Writes to the window store words in coprocessor memory. Reads are paced by a burst sequencer: the host arms it through configuration with a length code, and each window read then pulls one word until the burst is used up. The address can optionally step forward by one word after every window access.

Configuration bit 0 also holds the coprocessor in reset. When the host sets that bit, the block emits a one-cycle stop pulse. When the host clears it, the block emits a one-cycle start pulse and reinitialises its sticky flags. Two sticky flags are brought out as ports. One marks a window access that was refused. The other marks the address wrapping past its top.

Every register read returns data with a fixed latency of two clock edges, including window reads that wait on the one-cycle coprocessor memory.

Top module: `dsp_host_port`

## Requirements
- R1: After reset, status reads 0x0100, configuration reads 0x0000, the address reads 0x0000, and `host_rvalid`, `cop_start`, `cop_stop`, `win_err` and `addr_ovf` are all 0.
- R2: The host offsets are 0x0 window, 0x4 address, 0x8 configuration and 0xC status. A read sampled on one rising edge gives `host_rvalid` high, with its data, for exactly the cycle after the second rising edge. Reads come back in issue order. Any other offset reads 0.
- R3: Configuration bit 4 is the read trigger. A configuration write with bit 4 set arms a burst and sets status bits 0 (reading), 5 (read data full) and 6 (read data available). A configuration write with bit 4 clear cancels any burst and clears those three bits.
- R4: Configuration bits 3:2 choose the burst length: 0 gives 1 word, 1 gives 8, and 2 gives 16. Each window read while armed returns the memory word at the current address. Status bits 0, 5 and 6 clear after the last word of the burst.
- R5: Length code 3 gives an unlimited burst. Window reads never exhaust it.
- R6: With configuration bit 1 set, each accepted window read or write advances the address by one word. With bit 1 clear, the address stays where it is.
- R7: An accepted window write drives exactly one memory write of the host data at the current address. Memory read and write are never asserted together.
- R8: A window read when no burst is armed returns 0, issues no memory read, and sets the sticky `win_err`.
- R9: When the address steps from 0xFFFF it becomes 0x0000 and the sticky `addr_ovf` is set.
- R10: A configuration write that sets bit 0 pulses `cop_stop` for one cycle. A write that clears bit 0 after it was set pulses `cop_start` for one cycle and clears `win_err` and `addr_ovf`. The burst state then follows bit 4 of that same write.
- R11: When configuration bits 15:12 are nonzero, window reads and writes do not reach memory. Reads return 0 and both kinds set `win_err`. Configuration reads back exactly as written.
- R12: Status bit 8 (write path empty) always reads 1, and bit 7 (write path full) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (ignored while host_wr is high) |
| host_addr | input | 4 | Host byte offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, two edges after the request |
| mem_addr | output | 16 | Coprocessor memory word address |
| mem_re | output | 1 | Coprocessor memory read enable |
| mem_we | output | 1 | Coprocessor memory write enable |
| mem_wdata | output | 16 | Coprocessor memory write data |
| mem_rdata | input | 16 | Coprocessor memory read data, one cycle after mem_re |
| cop_start | output | 1 | One-cycle pulse when coprocessor reset is released |
| cop_stop | output | 1 | One-cycle pulse when coprocessor reset is asserted |
| win_err | output | 1 | Sticky refused-window-access flag |
| addr_ovf | output | 1 | Sticky address wrap flag |

## Verification
The hardest state to reach from the ports is the address wrap. It needs the address parked at 0xFFFF with stepping enabled, followed by a window access. The stimulus loads 0xFFFF, makes one stepping write, and then reads the address back as zero. It then rewinds to 0xFFFF without stepping, to prove the word landed at the top address.

Clearing the sticky flags is also hard to reach. It takes a full set-then-release pass through the coprocessor reset bit, so the bench clears them before it provokes a fresh region-refusal error. Exhaustion at exactly the final burst word is covered as well: status is checked one read before the end and again just after it.

// File: rtl/dhp_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register offsets, configuration field positions and
// burst-length decoding for the host window onto coprocessor memory.
package dhp_pkg;
    localparam int DW        = 16;
    localparam int AW        = 16;
    localparam int OFS_W     = 4;
    localparam int MAX_BURST = 16;
    localparam int CNT_W     = $clog2(MAX_BURST + 1);

    localparam logic [OFS_W-1:0] OFS_WIN  = 4'h0;
    localparam logic [OFS_W-1:0] OFS_ADDR = 4'h4;
    localparam logic [OFS_W-1:0] OFS_CFG  = 4'h8;
    localparam logic [OFS_W-1:0] OFS_STAT = 4'hC;

    localparam int CB_HOLD = 0;
    localparam int CB_STEP = 1;
    localparam int CB_LENL = 2;
    localparam int CB_TRIG = 4;
    localparam int CB_REGL = 12;

    localparam int SB_READING = 0;
    localparam int SB_RFULL   = 5;
    localparam int SB_RAVAIL  = 6;
    localparam int SB_WFULL   = 7;
    localparam int SB_WEMPTY  = 8;

    // Word count for a length code; code 3 (unlimited) yields 0 here.
    function automatic logic [CNT_W-1:0] burst_words(input logic [1:0] code);
        case (code)
            2'd0:    burst_words = CNT_W'(1);
            2'd1:    burst_words = CNT_W'(8);
            2'd2:    burst_words = CNT_W'(MAX_BURST);
            default: burst_words = '0;
        endcase
    endfunction
endpackage

// File: rtl/dhp_cfg_reg.sv
`timescale 1ns/1ps
// Configuration register and coprocessor reset edge detector.
// Assumes one host write per cycle; cfg_we is already qualified by offset.
// Emits registered one-cycle start/stop pulses and a combinational reinit
// strobe that other units consume on the same edge as the write.
module dhp_cfg_reg
    import dhp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg_q,
    output logic          step_en,
    output logic [1:0]    len_code,
    output logic          region_ok,
    output logic          reinit,
    output logic          start_o,
    output logic          stop_o
);
    // Register write and edge detection on the hold bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            start_o <= 1'b0;
            stop_o  <= 1'b0;
        end else begin
            start_o <= cfg_we && !wdata[CB_HOLD] && cfg_q[CB_HOLD];
            stop_o  <= cfg_we && wdata[CB_HOLD] && !cfg_q[CB_HOLD];
            if (cfg_we)
                cfg_q <= wdata;
        end
    end

    // Field decode of the held configuration.
    always_comb begin
        step_en   = cfg_q[CB_STEP];
        len_code  = cfg_q[CB_LENL +: 2];
        region_ok = (cfg_q[CB_REGL +: 4] == 4'd0);
        reinit    = cfg_we && !wdata[CB_HOLD] && cfg_q[CB_HOLD];
    end

    p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    p_start_stop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: rtl/dhp_burst_ctr.sv
`timescale 1ns/1ps
// Read burst sequencer: holds the remaining word count and the armed flag.
// Assumes pop is only asserted for accepted window reads (while armed).
module dhp_burst_ctr
    import dhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       trig,
    input  logic [1:0] len_code,
    input  logic       pop,
    output logic       active_q
);
    logic [CNT_W-1:0] cnt_q;
    logic             unlim_q;

    // Arm, cancel or count down the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            unlim_q  <= 1'b0;
            active_q <= 1'b0;
        end else if (cfg_we) begin
            cnt_q    <= trig ? burst_words(len_code) : '0;
            unlim_q  <= trig && (len_code == 2'd3);
            active_q <= trig;
        end else if (pop && !unlim_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1))
                active_q <= 1'b0;
        end
    end

    p_pop_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> active_q);
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !cfg_we && !unlim_q) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    p_last_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !cfg_we && !unlim_q && cnt_q == CNT_W'(1)) |=> !active_q);
    p_unlimited_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlim_q && active_q && !cfg_we) |=> active_q);
endmodule

// File: rtl/dhp_addr_ctr.sv
`timescale 1ns/1ps
// Word address register with optional post-access increment and a sticky
// wrap flag. Assumes addr_we and step are never both high in one cycle.
module dhp_addr_ctr
    import dhp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic [AW-1:0] wdata,
    input  logic          step,
    input  logic          reinit,
    output logic [AW-1:0] addr_q,
    output logic          ovf_q
);
    // Address load or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (addr_we)
            addr_q <= wdata;
        else if (step)
            addr_q <= addr_q + AW'(1);
    end

    // Sticky wrap flag, cleared on coprocessor reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (reinit)
            ovf_q <= 1'b0;
        else if (step && (addr_q == '1))
            ovf_q <= 1'b1;
    end

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_we && addr_q == '1) |=> (ovf_q && addr_q == '0));
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !reinit) |=> ovf_q);
endmodule

// File: rtl/dhp_rd_pipe.sv
`timescale 1ns/1ps
// Two-stage read return path. Stage one records the request and either a
// register snapshot or a pending memory word; stage two presents the data.
// Assumes the memory returns read data one cycle after mem_re.
module dhp_rd_pipe
    import dhp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_mem,
    input  logic [DW-1:0] req_data,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic          s1_v;
    logic          s1_m;
    logic [DW-1:0] s1_d;

    // Capture request and return data two edges later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_m   <= 1'b0;
            s1_d   <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            s1_v   <= req;
            s1_m   <= req && req_mem;
            s1_d   <= req_data;
            rvalid <= s1_v;
            if (s1_v)
                rdata <= s1_m ? mem_rdata : s1_d;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ##1 rvalid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_v |=> !rvalid);
endmodule

// File: rtl/dsp_host_port.sv
`timescale 1ns/1ps
// Top: host register window onto coprocessor data memory.
// Decodes the host offset, gates window accesses by burst state and region,
// drives the memory port combinationally from the current address, and
// collects the refused-access flag. Assumes host_wr has priority over host_rd.
module dsp_host_port
    import dhp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [OFS_W-1:0] host_addr,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             host_rvalid,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_re,
    output logic             mem_we,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             cop_start,
    output logic             cop_stop,
    output logic             win_err,
    output logic             addr_ovf
);
    logic          rd_acc, win_rd, win_wr, rd_ok, wr_ok, step;
    logic          cfg_we, addr_we;
    logic [DW-1:0] cfg_q, status, snap;
    logic          step_en, region_ok, reinit, active;
    logic [1:0]    len_code;
    logic [AW-1:0] addr_q;

    // Access decode and window gating.
    always_comb begin
        rd_acc  = host_rd && !host_wr;
        win_rd  = rd_acc && (host_addr == OFS_WIN);
        win_wr  = host_wr && (host_addr == OFS_WIN);
        cfg_we  = host_wr && (host_addr == OFS_CFG);
        addr_we = host_wr && (host_addr == OFS_ADDR);
        rd_ok   = win_rd && active && region_ok;
        wr_ok   = win_wr && region_ok;
        step    = (rd_ok || wr_ok) && step_en;
    end

    // Memory port drive.
    always_comb begin
        mem_addr  = addr_q;
        mem_re    = rd_ok;
        mem_we    = wr_ok;
        mem_wdata = host_wdata;
    end

    // Status word and register snapshot for the read pipe.
    always_comb begin
        status             = '0;
        status[SB_READING] = active;
        status[SB_RFULL]   = active;
        status[SB_RAVAIL]  = active;
        status[SB_WFULL]   = 1'b0;
        status[SB_WEMPTY]  = 1'b1;
        case (host_addr)
            OFS_ADDR: snap = DW'(addr_q);
            OFS_CFG:  snap = cfg_q;
            OFS_STAT: snap = status;
            default:  snap = '0;
        endcase
    end

    // Sticky refused-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_err <= 1'b0;
        else if (reinit)
            win_err <= 1'b0;
        else if ((win_rd && !rd_ok) || (win_wr && !wr_ok))
            win_err <= 1'b1;
    end

    dhp_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .wdata     (host_wdata),
        .cfg_q     (cfg_q),
        .step_en   (step_en),
        .len_code  (len_code),
        .region_ok (region_ok),
        .reinit    (reinit),
        .start_o   (cop_start),
        .stop_o    (cop_stop)
    );

    dhp_burst_ctr u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .trig     (host_wdata[CB_TRIG]),
        .len_code (host_wdata[CB_LENL +: 2]),
        .pop      (rd_ok),
        .active_q (active)
    );

    dhp_addr_ctr u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_we (addr_we),
        .wdata   (AW'(host_wdata)),
        .step    (step),
        .reinit  (reinit),
        .addr_q  (addr_q),
        .ovf_q   (addr_ovf)
    );

    dhp_rd_pipe u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (rd_acc),
        .req_mem   (rd_ok),
        .req_data  (snap),
        .mem_rdata (mem_rdata),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid)
    );

    p_mem_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_err && !reinit) |=> win_err);
    p_region_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !region_ok |-> !(mem_re || mem_we));
endmodule

// File: tb/dsp_host_port_test.sv
`timescale 1ns/1ps
// Scoreboard bench: bus_rd pushes expected read data, a monitor pops and
// compares on every returned word; direct checks cover pulses and flags.
module dsp_host_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        host_rvalid, mem_re, mem_we, cop_start, cop_stop, win_err, addr_ovf;

    int nchk = 0, nfail = 0, nre = 0, nwr = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] bmem [int];

    always #2.5 clk = ~clk;

    dsp_host_port uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cop_start(cop_start), .cop_stop(cop_stop), .win_err(win_err),
        .addr_ovf(addr_ovf)
    );

    function automatic logic [15:0] fdef(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] peek(input logic [15:0] a);
        if (bmem.exists(int'(a))) return bmem[int'(a)];
        return fdef(a);
    endfunction

    // Coprocessor memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) begin
            bmem[int'(mem_addr)] = mem_wdata;
            nwr++;
        end
        if (mem_re) begin
            mem_rdata <= peek(mem_addr);
            nre++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every returned word against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R2 unexpected return", host_rdata, 16'h0000);
            else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(host_rdata == e, t, host_rdata, e);
            end
        end
    end

    task automatic bus_wr(input logic [3:0] ofs, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = ofs; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] ofs, input logic [15:0] e, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = ofs;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 outstanding reads", 16'(exp_q.size()), 16'h0000);
    endtask

    task automatic reinit_port();
        bus_wr(4'h8, 16'h0001);
        bus_wr(4'h8, 16'h0000);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int r0, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!host_rvalid && !cop_start && !cop_stop, "R1 idle outputs", {13'b0, host_rvalid, cop_start, cop_stop}, 16'h0);
        chk(!win_err && !addr_ovf, "R1 flags clear", {14'b0, win_err, addr_ovf}, 16'h0);
        bus_rd(4'hC, 16'h0100, "R1 R12 status after reset");
        bus_rd(4'h8, 16'h0000, "R1 config after reset");
        bus_rd(4'h4, 16'h0000, "R1 address after reset");
        bus_rd(4'h2, 16'h0000, "R2 unmapped offset");
        drain();

        // R2 latency
        @(negedge clk);
        host_rd = 1'b1; host_addr = 4'hC;
        exp_q.push_back(16'h0100); tag_q.push_back("R2 latency data");
        @(negedge clk);
        host_rd = 1'b0;
        chk(host_rvalid == 1'b0, "R2 not after one edge", 16'(host_rvalid), 16'h0);
        @(negedge clk);
        chk(host_rvalid == 1'b1, "R2 valid after two edges", 16'(host_rvalid), 16'h1);
        drain();

        // R10 reset edges
        bus_wr(4'h8, 16'h0001);
        chk(cop_stop && !cop_start, "R10 stop pulse", {14'b0, cop_stop, cop_start}, 16'h2);
        @(negedge clk);
        chk(!cop_stop, "R10 stop one cycle", 16'(cop_stop), 16'h0);
        bus_wr(4'h8, 16'h0000);
        chk(cop_start && !cop_stop, "R10 start pulse", {14'b0, cop_start, cop_stop}, 16'h2);
        @(negedge clk);
        chk(!cop_start, "R10 start one cycle", 16'(cop_start), 16'h0);

        // R3 R4 single-word burst, then R8 empty read
        bus_wr(4'h4, 16'h0010);
        bus_wr(4'h8, 16'h0012);
        bus_rd(4'hC, 16'h0161, "R3 armed status");
        bus_rd(4'h0, fdef(16'h0010), "R4 single word");
        bus_rd(4'hC, 16'h0100, "R4 single exhausted");
        drain();
        r0 = nre;
        bus_rd(4'h0, 16'h0000, "R8 empty read data");
        chk(win_err, "R8 error flag set", 16'(win_err), 16'h1);
        chk(nre == r0, "R8 no memory read", 16'(nre - r0), 16'h0);
        drain();

        // R4 eight-word burst with stepping (R6)
        bus_wr(4'h4, 16'h0020);
        bus_wr(4'h8, 16'h0016);
        for (int i = 0; i < 7; i++)
            bus_rd(4'h0, fdef(16'h0020 + 16'(i)), "R4 R6 burst8 word");
        bus_rd(4'hC, 16'h0161, "R4 burst8 before last");
        bus_rd(4'h0, fdef(16'h0027), "R4 burst8 last word");
        bus_rd(4'hC, 16'h0100, "R4 burst8 exhausted");
        bus_rd(4'h4, 16'h0028, "R6 address advanced");
        drain();

        // R4 sixteen-word burst without stepping (R6)
        bus_wr(4'h4, 16'h0040);
        bus_wr(4'h8, 16'h0018);
        for (int i = 0; i < 16; i++)
            bus_rd(4'h0, fdef(16'h0040), "R4 R6 burst16 fixed address");
        bus_rd(4'hC, 16'h0100, "R4 burst16 exhausted");
        bus_rd(4'h4, 16'h0040, "R6 address held");
        drain();

        // R5 unlimited
        bus_wr(4'h4, 16'h0050);
        bus_wr(4'h8, 16'h001E);
        for (int i = 0; i < 20; i++)
            bus_rd(4'h0, fdef(16'h0050 + 16'(i)), "R5 unlimited word");
        bus_rd(4'hC, 16'h0161, "R5 still armed");
        bus_wr(4'h8, 16'h0002);
        bus_rd(4'hC, 16'h0100, "R3 trigger clear");
        drain();

        // R7 window writes
        w0 = nwr;
        bus_wr(4'h4, 16'h0100);
        bus_wr(4'h0, 16'h1111);
        bus_wr(4'h0, 16'h2222);
        bus_wr(4'h0, 16'h3333);
        chk(nwr - w0 == 3, "R7 write count", 16'(nwr - w0), 16'h3);
        bus_rd(4'h4, 16'h0103, "R6 address after writes");
        bus_wr(4'h4, 16'h0100);
        bus_wr(4'h8, 16'h0016);
        bus_rd(4'h0, 16'h1111, "R7 readback 0");
        bus_rd(4'h0, 16'h2222, "R7 readback 1");
        bus_rd(4'h0, 16'h3333, "R7 readback 2");
        bus_wr(4'h8, 16'h0002);
        drain();

        // R9 wrap
        chk(!addr_ovf, "R9 flag clear before wrap", 16'(addr_ovf), 16'h0);
        bus_wr(4'h4, 16'hFFFF);
        bus_wr(4'h0, 16'hBEEF);
        chk(addr_ovf, "R9 wrap flag", 16'(addr_ovf), 16'h1);
        bus_rd(4'h4, 16'h0000, "R9 address wrapped");
        bus_wr(4'h4, 16'hFFFF);
        bus_wr(4'h8, 16'h0010);
        bus_rd(4'h0, 16'hBEEF, "R9 top word stored");
        drain();

        // R10 release clears sticky flags
        reinit_port();
        chk(!win_err && !addr_ovf, "R10 flags cleared", {14'b0, win_err, addr_ovf}, 16'h0);

        // R11 foreign region blocked
        w0 = nwr; r0 = nre;
        bus_wr(4'h8, 16'h1012);
        bus_rd(4'h8, 16'h1012, "R11 config readback");
        bus_wr(4'h4, 16'h0200);
        bus_wr(4'h0, 16'h7777);
        chk(win_err, "R11 write refused flag", 16'(win_err), 16'h1);
        bus_rd(4'h0, 16'h0000, "R11 read refused data");
        drain();
        chk(nwr == w0 && nre == r0, "R11 no memory access", 16'(nwr - w0 + nre - r0), 16'h0);
        bus_rd(4'h4, 16'h0200, "R11 address not stepped");
        bus_wr(4'h8, 16'h0010);
        bus_rd(4'h0, fdef(16'h0200), "R11 memory untouched");
        drain();

        // R10 release combined with trigger, R12 status constants
        bus_wr(4'h8, 16'h0001);
        bus_wr(4'h8, 16'h0010);
        chk(cop_start, "R10 start with trigger", 16'(cop_start), 16'h1);
        bus_rd(4'hC, 16'h0161, "R10 R12 armed after release");
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule